// File: doc/BRIEF.md
# Calendar Clock with Alarm Comparator

This block keeps wall-clock time from a slow tick enable. The tick is a 32.768 kHz enable pulse in the system clock domain. A prescaler divides it down to 1/256 s steps. Each step advances a chain of counters: a binary sub-second byte, then seconds, minutes and hours. When the hours counter wraps, a day-of-week counter and a free-running 16-bit binary day number also advance. The day number has no month or year meaning. Software gives it whatever meaning it needs.

Software reaches every field through one flat address space, using a single-cycle write strobe and a combinational read port. A control word holds the run bit, the alarm arm bit, the interrupt enable, the sticky alarm flag and four per-field match selects. The alarm comparator runs once per step against the time being entered. Selecting no field therefore gives a match on every step, 256 times per second. Selecting the sub-second, seconds, minutes and hours fields together gives one match per day.

Top module: `cal_clock`

## Requirements
- R1: Address map, 16-bit data: 0 sub-second (8 b), 1 seconds (6 b), 2 minutes (6 b), 3 hours (5 b), 4 day of week (3 b), 5 day number (16 b), 6 control, 8..11 alarm sub-second/seconds/minutes/hours. A write stores the low bits of the data on the next clock edge. Reads return the field zero-extended. Addresses 7 and 12..15 read 0. After reset every field, alarm value and control bit reads 0.
- R2: With control bit 0 (run) set, the sub-second field advances by one on every PRESCALE-th cycle in which tick_en is high (PRESCALE defaults to 128).
- R3: With run clear, or with tick_en low, every time field holds its value.
- R4: When sub-second wraps from 255 to 0, seconds advance. Seconds and minutes go from any value of 59 or more to 0 and carry. Hours go from any value of 23 or more to 0 and carry.
- R5: An hour carry moves day of week forward, from any value of 6 or more to 0, and increments the day number, which wraps from 65535 to 0.
- R6: A write to the sub-second field restarts the prescaler, so the next step needs a full PRESCALE ticks.
- R7: With control bit 1 (arm) set, a step sets the alarm flag (control bit 3) when every field selected by control bits 4..7 (sub-second, seconds, minutes, hours in that order) equals its alarm value in the time the step enters.
- R8: With arm set and no select bit set, every step sets the flag.
- R9: The flag is sticky. Only a control write with bit 3 at 0 clears it. Writing 1 there never sets it, and a match in the same cycle as the clearing write wins.
- R10: irq is high exactly while the flag and control bit 2 (interrupt enable) are both set. With arm clear, the flag never sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | 32.768 kHz timebase enable, one cycle per tick |
| wr_en | input | 1 | Write strobe for the addressed field |
| addr | input | 4 | Field address for write and read |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Combinational read of the addressed field |
| irq | output | 1 | Alarm interrupt request |

## Verification
A write lands on the edge that follows its strobe. A step lands on the edge of the PRESCALE-th qualifying tick. The alarm flag and irq change on that same edge, because the comparator looks at the time being entered rather than the time already held. The bench therefore drives tick_en for an exact number of cycles, changes inputs only on falling edges, and reads the outputs one falling edge later. It never needs to count pipeline slack. Each expected time is computed arithmetically from the start time and the number of elapsed steps, then checked field by field. The sweeps cover every hour rollover, every day-of-week wrap, the day-number wrap, and runs of several hundred steps.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int SUB_W = 8;
    localparam int SEC_W = 6;
    localparam int MIN_W = 6;
    localparam int HR_W  = 5;
    localparam int DOW_W = 3;
    localparam int DAY_W = 16;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] A_SUB    = 4'd0;
    localparam logic [ADDR_W-1:0] A_SEC    = 4'd1;
    localparam logic [ADDR_W-1:0] A_MIN    = 4'd2;
    localparam logic [ADDR_W-1:0] A_HR     = 4'd3;
    localparam logic [ADDR_W-1:0] A_DOW    = 4'd4;
    localparam logic [ADDR_W-1:0] A_DAY    = 4'd5;
    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd6;
    localparam logic [ADDR_W-1:0] A_AL_SUB = 4'd8;
    localparam logic [ADDR_W-1:0] A_AL_SEC = 4'd9;
    localparam logic [ADDR_W-1:0] A_AL_MIN = 4'd10;
    localparam logic [ADDR_W-1:0] A_AL_HR  = 4'd11;

    localparam logic [SEC_W-1:0] SEC_TOP = 6'd59;
    localparam logic [MIN_W-1:0] MIN_TOP = 6'd59;
    localparam logic [HR_W-1:0]  HR_TOP  = 5'd23;
    localparam logic [DOW_W-1:0] DOW_TOP = 3'd6;

    typedef struct packed {
        logic [SUB_W-1:0] sub;
        logic [SEC_W-1:0] sec;
        logic [MIN_W-1:0] min;
        logic [HR_W-1:0]  hr;
        logic [DOW_W-1:0] dow;
        logic [DAY_W-1:0] day;
    } cal_time_t;

    typedef struct packed {
        logic [SUB_W-1:0] sub;
        logic [SEC_W-1:0] sec;
        logic [MIN_W-1:0] min;
        logic [HR_W-1:0]  hr;
    } cal_alarm_t;

    typedef struct packed {
        logic [3:0] sel;
        logic       ie;
        logic       arm;
        logic       run;
    } cal_ctrl_t;
endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int PRESCALE = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick_en,
    input  logic restart,
    output logic step
);
    localparam int CW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        step = 1'b0;
        if (restart) begin
            st_d.cnt = '0;
        end else if (run && tick_en) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
                step     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cal_time_chain.sv
module cal_time_chain
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output cal_time_t         now,
    output cal_time_t         upcoming
);
    cal_time_t tm_d, tm_q;
    logic c_sec, c_min, c_hr, c_day;

    always_comb begin
        tm_d  = tm_q;
        c_sec = step && (tm_q.sub == {SUB_W{1'b1}});
        c_min = c_sec && (tm_q.sec >= SEC_TOP);
        c_hr  = c_min && (tm_q.min >= MIN_TOP);
        c_day = c_hr && (tm_q.hr >= HR_TOP);

        if (step)  tm_d.sub = tm_q.sub + 1'b1;
        if (c_sec) tm_d.sec = (tm_q.sec >= SEC_TOP) ? '0 : tm_q.sec + 1'b1;
        if (c_min) tm_d.min = (tm_q.min >= MIN_TOP) ? '0 : tm_q.min + 1'b1;
        if (c_hr)  tm_d.hr  = (tm_q.hr >= HR_TOP) ? '0 : tm_q.hr + 1'b1;
        if (c_day) begin
            tm_d.dow = (tm_q.dow >= DOW_TOP) ? '0 : tm_q.dow + 1'b1;
            tm_d.day = tm_q.day + 1'b1;
        end

        if (wr_en) begin
            case (addr)
                A_SUB: tm_d.sub = wr_data[SUB_W-1:0];
                A_SEC: tm_d.sec = wr_data[SEC_W-1:0];
                A_MIN: tm_d.min = wr_data[MIN_W-1:0];
                A_HR:  tm_d.hr  = wr_data[HR_W-1:0];
                A_DOW: tm_d.dow = wr_data[DOW_W-1:0];
                A_DAY: tm_d.day = wr_data[DAY_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign now      = tm_q;
    assign upcoming = tm_d;
endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              arm,
    input  logic [3:0]        sel,
    input  cal_time_t         upcoming,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output cal_alarm_t        alm,
    output logic              flag
);
    typedef struct packed {
        cal_alarm_t al;
        logic       flag;
    } al_state_t;

    al_state_t st_d, st_q;
    logic [3:0] fld_eq;
    logic       hit;

    always_comb begin
        fld_eq[0] = upcoming.sub == st_q.al.sub;
        fld_eq[1] = upcoming.sec == st_q.al.sec;
        fld_eq[2] = upcoming.min == st_q.al.min;
        fld_eq[3] = upcoming.hr  == st_q.al.hr;
        hit = step && arm && ((fld_eq | ~sel) == 4'hF);

        st_d = st_q;
        if (wr_en) begin
            case (addr)
                A_AL_SUB: st_d.al.sub = wr_data[SUB_W-1:0];
                A_AL_SEC: st_d.al.sec = wr_data[SEC_W-1:0];
                A_AL_MIN: st_d.al.min = wr_data[MIN_W-1:0];
                A_AL_HR:  st_d.al.hr  = wr_data[HR_W-1:0];
                A_CTRL:   st_d.flag   = st_q.flag & wr_data[3];
                default: ;
            endcase
        end
        if (hit) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alm  = st_q.al;
    assign flag = st_q.flag;
endmodule

// File: rtl/cal_clock.sv
module cal_clock
    import cal_pkg::*;
#(
    parameter int PRESCALE = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    cal_ctrl_t  ctrl_d, ctrl_q;
    cal_time_t  now_t, next_t;
    cal_alarm_t alm;
    logic       step, run_en, alarm_flag, sub_wr;

    assign run_en = ctrl_q.run;
    assign sub_wr = wr_en && (addr == A_SUB);

    cal_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run_en), .tick_en(tick_en),
        .restart(sub_wr), .step(step)
    );

    cal_time_chain u_chain (
        .clk(clk), .rst_n(rst_n), .step(step), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .now(now_t), .upcoming(next_t)
    );

    cal_alarm u_alarm (
        .clk(clk), .rst_n(rst_n), .step(step), .arm(ctrl_q.arm),
        .sel(ctrl_q.sel), .upcoming(next_t), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .alm(alm), .flag(alarm_flag)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en && addr == A_CTRL) begin
            ctrl_d.run = wr_data[0];
            ctrl_d.arm = wr_data[1];
            ctrl_d.ie  = wr_data[2];
            ctrl_d.sel = wr_data[7:4];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    always_comb begin
        case (addr)
            A_SUB:    rd_data = {{(DATA_W-SUB_W){1'b0}}, now_t.sub};
            A_SEC:    rd_data = {{(DATA_W-SEC_W){1'b0}}, now_t.sec};
            A_MIN:    rd_data = {{(DATA_W-MIN_W){1'b0}}, now_t.min};
            A_HR:     rd_data = {{(DATA_W-HR_W){1'b0}}, now_t.hr};
            A_DOW:    rd_data = {{(DATA_W-DOW_W){1'b0}}, now_t.dow};
            A_DAY:    rd_data = now_t.day;
            A_CTRL:   rd_data = {8'd0, ctrl_q.sel, alarm_flag, ctrl_q.ie,
                                 ctrl_q.arm, ctrl_q.run};
            A_AL_SUB: rd_data = {{(DATA_W-SUB_W){1'b0}}, alm.sub};
            A_AL_SEC: rd_data = {{(DATA_W-SEC_W){1'b0}}, alm.sec};
            A_AL_MIN: rd_data = {{(DATA_W-MIN_W){1'b0}}, alm.min};
            A_AL_HR:  rd_data = {{(DATA_W-HR_W){1'b0}}, alm.hr};
            default:  rd_data = '0;
        endcase
    end

    assign irq = alarm_flag && ctrl_q.ie;
endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk
    import cal_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              step,
    input logic              run,
    input cal_time_t         now,
    input logic              flag
);
    AST_SUB_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        step && !wr_en |=> now.sub == $past(now.sub) + 8'd1); // R2

    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !wr_en |=> $stable(now)); // R3

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        step && !wr_en && now.sub == 8'hFF && now.sec == 6'd59 |=> now.sec == 6'd0); // R4

    AST_FLAG_FROM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(step)); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !(wr_en && addr == A_CTRL) |=> flag); // R9
endmodule

bind cal_clock cal_clock_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .step(step),
    .run(run_en), .now(now_t), .flag(alarm_flag)
);

// File: tb/tb_cal_clock.sv
module tb_cal_clock;
    localparam int PS = 4;
    localparam longint DAYSTEPS = 64'd22118400;

    logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, wr_en = 1'b0, irq;
    logic [3:0]  addr = '0;
    logic [15:0] wr_data = '0, rd_data;
    int n_chk = 0, n_bad = 0;

    cal_clock #(.PRESCALE(PS)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    always #10 clk = ~clk;

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, act=hung exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        addr = a; #1; v = rd_data;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic set_time(input int s, sc, mi, h, dw, dy);
        wr(4'd1, 16'(sc)); wr(4'd2, 16'(mi)); wr(4'd3, 16'(h));
        wr(4'd4, 16'(dw)); wr(4'd5, 16'(dy)); wr(4'd0, 16'(s));
    endtask

    task automatic chk_time(input string req, input int s, sc, mi, h, dw, dy);
        logic [15:0] v;
        rd(4'd0, v); chk({req, " sub"}, v, s);
        rd(4'd1, v); chk({req, " sec"}, v, sc);
        rd(4'd2, v); chk({req, " min"}, v, mi);
        rd(4'd3, v); chk({req, " hour"}, v, h);
        rd(4'd4, v); chk({req, " dow"}, v, dw);
        rd(4'd5, v); chk({req, " day"}, v, dy);
    endtask

    // start time, steps elapsed -> expected fields by arithmetic
    task automatic run_model(input string req, input int s, sc, mi, h, dw, dy, input int steps);
        longint tot, days, r;
        set_time(s, sc, mi, h, dw, dy);
        ticks(steps * PS);
        tot  = s + 256 * (sc + 60 * (mi + 60 * longint'(h))) + steps;
        days = tot / DAYSTEPS;
        r    = tot % DAYSTEPS;
        chk_time(req, int'(r % 256), int'((r / 256) % 60), int'((r / 15360) % 60),
                 int'(r / 921600), int'((dw + days) % 7), int'((dy + days) % 65536));
    endtask

    task automatic flag_is(input string req, input int exp_flag, input int exp_irq);
        logic [15:0] v;
        rd(4'd6, v);
        chk({req, " flag"}, v[3], exp_flag);
        chk({req, " irq"}, irq, exp_irq);
    endtask

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state, R1
        for (int a = 0; a < 16; a++) begin rd(4'(a), v); chk("R1 reset", v, 0); end
        chk("R10 reset irq", irq, 0);

        // R1 write/read, masking and unused addresses
        wr(4'd0, 16'hFFAB); wr(4'd1, 16'd45); wr(4'd2, 16'hFFFF); wr(4'd3, 16'd17);
        wr(4'd4, 16'd5); wr(4'd5, 16'hBEEF); wr(4'd8, 16'h1234); wr(4'd9, 16'd7);
        wr(4'd10, 16'd33); wr(4'd11, 16'd22); wr(4'd7, 16'hFFFF); wr(4'd12, 16'hFFFF);
        rd(4'd0, v); chk("R1 sub", v, 16'hAB);   rd(4'd1, v); chk("R1 sec", v, 45);
        rd(4'd2, v); chk("R1 min", v, 63);       rd(4'd3, v); chk("R1 hour", v, 17);
        rd(4'd4, v); chk("R1 dow", v, 5);        rd(4'd5, v); chk("R1 day", v, 16'hBEEF);
        rd(4'd8, v); chk("R1 al sub", v, 16'h34); rd(4'd9, v); chk("R1 al sec", v, 7);
        rd(4'd10, v); chk("R1 al min", v, 33);   rd(4'd11, v); chk("R1 al hr", v, 22);
        rd(4'd7, v); chk("R1 gap", v, 0);        rd(4'd12, v); chk("R1 gap", v, 0);
        wr(4'd6, 16'h00F7);
        rd(4'd6, v); chk("R1 ctrl", v, 16'h00F7 & 16'hFFF7);

        // R3 freeze: run clear with ticks, then run set without ticks
        wr(4'd6, 16'h0000);
        set_time(10, 20, 30, 4, 2, 100);
        ticks(10 * PS);
        chk_time("R3 run off", 10, 20, 30, 4, 2, 100);
        wr(4'd6, 16'h0001);
        repeat (40) @(negedge clk);
        chk_time("R3 no tick", 10, 20, 30, 4, 2, 100);

        // R2 prescale count
        ticks(PS - 1); rd(4'd0, v); chk("R2 before step", v, 10);
        ticks(1);      rd(4'd0, v); chk("R2 at step", v, 11);
        ticks(5 * PS); rd(4'd0, v); chk("R2 five steps", v, 16);

        // R6 sub write restarts prescaler
        ticks(PS - 2);
        wr(4'd0, 16'd50);
        ticks(PS - 1); rd(4'd0, v); chk("R6 restarted", v, 50);
        ticks(1);      rd(4'd0, v); chk("R6 full period", v, 51);

        // R4 R5 sweep of every hour rollover
        for (int h = 0; h < 24; h++)
            run_model("R4 hour sweep", 255, 59, 59, h, h % 7, h * 2731, 1);
        // R5 day of week sweep, day number wrap
        for (int d = 0; d < 7; d++)
            run_model("R5 dow sweep", 255, 59, 59, 23, d, 65529 + d, 1);
        // longer runs from assorted starts
        for (int k = 0; k < 8; k++)
            run_model("R4 long run", (k * 53) % 256, (k * 17 + 50) % 60, 59 - k, 23 - (k % 2),
                      k % 7, 65535 - k, 300 + 97 * k);

        // R4 out of range seconds wraps with carry
        set_time(255, 62, 10, 3, 0, 0);
        ticks(PS);
        chk_time("R4 out of range", 0, 0, 11, 3, 0, 0);

        // R7 seconds-only match, R10 irq
        set_time(254, 2, 0, 0, 0, 0);
        wr(4'd9, 16'd3);
        wr(4'd6, 16'h0027);
        ticks(PS); flag_is("R7 no match yet", 0, 0);
        ticks(PS); flag_is("R7 match", 1, 1);
        wr(4'd6, 16'h0023); flag_is("R9 cleared", 0, 0);
        ticks(PS); flag_is("R10 ie off", 1, 0);
        wr(4'd6, 16'h002F); flag_is("R9 write one keeps", 1, 1);
        wr(4'd6, 16'h0001);
        ticks(PS); flag_is("R10 disarmed", 0, 0);
        wr(4'd6, 16'h0009); flag_is("R9 write one no set", 0, 0);

        // R8 no selects
        wr(4'd6, 16'h0003);
        ticks(PS - 1); flag_is("R8 between steps", 0, 0);
        ticks(1);      flag_is("R8 each step", 1, 0);
        wr(4'd6, 16'h0003);
        ticks(PS);     flag_is("R8 next step", 1, 0);

        // R7 all fields exact instant
        wr(4'd8, 16'd10); wr(4'd9, 16'd5); wr(4'd10, 16'd7); wr(4'd11, 16'd9);
        set_time(8, 5, 7, 9, 1, 1);
        wr(4'd6, 16'h00F7);
        ticks(PS); flag_is("R7 all off by one", 0, 0);
        ticks(PS); flag_is("R7 all match", 1, 1);
        wr(4'd6, 16'h00F7);
        ticks(PS); flag_is("R7 all past", 0, 0);

        // R9 match wins over clearing write in same cycle
        wr(4'd6, 16'h0007);
        @(negedge clk); tick_en = 1'b1;
        repeat (PS - 1) @(negedge clk);
        addr = 4'd6; wr_data = 16'h0007; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0; tick_en = 1'b0;
        flag_is("R9 match beats clear", 1, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule